// File: doc/BRIEF.md
# Hours-and-Hundredths Time-of-Day Counter

This block keeps the time of day as four BCD digits. The upper two digits count hours and the lower two count hundredths of an hour. It does not use minutes and seconds. The count advances in steps of two hundredths of an hour. One step lasts 72 seconds of real time. A prescaler turns the system clock into one step every `PRESCALE` clock cycles.

Software reads the time through a request/response port. A request copies all four digits into a holding register on one clock edge. Because of that, a carry rippling through the digits can never be seen half done. A synchronous load port presets the whole time and restarts the prescaler. With the default parameters the counter covers one day, from 00.00 to 23.98, and then returns to 00.00.

Top module: `tod_hundredths_clock`

## Requirements
- R1: While `rst_n` is low, all four digits are zero and `rd_valid` is low. The prescaler also restarts, so the first step after release lands on the `PRESCALE`-th rising edge.
- R2: With no load, the time advances by exactly two hundredths once every `PRESCALE` clock cycles.
- R3: When the hundredths field moves past 98, it returns to 00 and carries one into the hours. When the hours units digit moves past 9, it returns to 0 and carries into the hours tens digit.
- R4: At 23.98, the next step gives 00.00.
- R5: The hundredths units digit only ever holds an even value. A load with an odd value in that digit has bit 0 cleared.
- R6: When `load_en` is high on a rising edge, all four digits take `load_time` on that edge and the prescaler restarts. If a step falls due on the same edge, the load wins and that step is dropped.
- R7: When `rd_req` is high on a rising edge, `rd_time` takes the time held just before that edge and `rd_valid` is high for the following cycle. Without a request, `rd_valid` is low and `rd_time` holds its value.
- R8: `load_time` and `rd_time` share one layout:
  - bits [15:12] are the hours tens digit;
  - bits [11:8] are the hours units digit;
  - bits [7:4] are the hundredths tens digit;
  - bits [3:0] are the hundredths units digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Preset the time from `load_time` |
| load_time | input | 16 | Four BCD digits to preset, layout per R8 |
| rd_req | input | 1 | Request a snapshot of the time |
| rd_time | output | 16 | Snapshot of the four BCD digits, layout per R8 |
| rd_valid | output | 1 | High for one cycle after a request |

## Verification
The bench reads the time on every cycle across three carry points:
- the hundredths rollover;
- the hours-units rollover into the tens digit;
- the end-of-day wrap.

A design that tears its snapshot would return mixed digits such as 0900 or 1098 instead of 0998 or 1000. A design that wraps at the wrong point would show 2400 or 0100. Further cases:
- An odd load value catches a design that lets the low digit go odd.
- A load placed exactly on a due step catches a design that lets the step win, which would return the loaded value plus two.
- A load placed exactly on a due step also catches a design that forgets to restart the prescaler, which would shift every later step.
- Reads of distinct digit values catch swapped digit order.

// File: rtl/tod_pkg.sv
package tod_pkg;

   localparam int unsigned TOD_DIGITS = 4;
   localparam int unsigned BCD_W      = 4;
   localparam int unsigned TOD_W      = TOD_DIGITS * BCD_W;

   typedef logic [BCD_W-1:0] bcd_t;

   // first member is most significant: hours tens at the top of the word
   typedef struct packed {
      bcd_t hr_tens;
      bcd_t hr_ones;
      bcd_t hu_tens;
      bcd_t hu_ones;
   } tod_time_t;

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
   parameter int unsigned PRESCALE = 72_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic step_o
);

   if (PRESCALE < 1) begin : g_bad_prescale
      $error("tod_prescaler: PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_every_cycle
      assign step_o = ~restart;
   end else begin : g_counted
      localparam int unsigned CNT_W = $clog2(PRESCALE);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || restart) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign step_o = (cnt_q == CNT_LAST) && !restart;

      // R2
      step_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         step_o |=> !step_o);
   end

endmodule

// File: rtl/tod_digit.sv
module tod_digit #(
   parameter int unsigned STEP = 1,
   parameter int unsigned LAST = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [3:0] load_val,
   input  logic       inc,
   input  logic       clr,
   output logic [3:0] val_o,
   output logic       carry_o
);

   if (LAST > 9 || STEP < 1 || STEP > 9) begin : g_bad_digit
      $error("tod_digit: STEP/LAST outside one decimal digit");
   end

   localparam logic [3:0] LAST_V = 4'(LAST);
   localparam logic [3:0] STEP_V = 4'(STEP);

   logic [3:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
      end else if (load) begin
         val_q <= load_val;
      end else if (inc) begin
         if (clr || val_q == LAST_V) begin
            val_q <= '0;
         end else begin
            val_q <= val_q + STEP_V;
         end
      end
   end

   assign val_o   = val_q;
   assign carry_o = inc && !clr && (val_q == LAST_V);

   // R3
   digit_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      val_q <= 4'd9);

endmodule

// File: rtl/tod_digit_chain.sv
module tod_digit_chain
   import tod_pkg::*;
#(
   parameter int unsigned HOURS_PER_DAY = 24,
   parameter int unsigned HU_STEP       = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  tod_time_t load_val,
   output tod_time_t time_o
);

   if (HOURS_PER_DAY < 2 || HOURS_PER_DAY > 100) begin : g_bad_hours
      $error("tod_digit_chain: HOURS_PER_DAY must be 2..100");
   end
   if (HU_STEP != 1 && HU_STEP != 2 && HU_STEP != 5) begin : g_bad_step
      $error("tod_digit_chain: HU_STEP must divide ten");
   end

   localparam bcd_t        HR_TOP_TENS = bcd_t'((HOURS_PER_DAY - 1) / 10);
   localparam bcd_t        HR_TOP_ONES = bcd_t'((HOURS_PER_DAY - 1) % 10);
   localparam int unsigned LOW_LAST    = 10 - HU_STEP;
   localparam bcd_t        LOW_LAST_V  = bcd_t'(LOW_LAST);

   function automatic bcd_t round_low(input bcd_t v);
      int unsigned t;
      t = int'(v);
      return bcd_t'(t - (t % HU_STEP));
   endfunction

   bcd_t       dig [TOD_DIGITS];
   bcd_t       ld  [TOD_DIGITS];
   logic [3:0] inc;
   logic [3:0] clr;
   logic [3:0] carry;
   logic       hr_wrap;

   assign ld[0] = round_low(load_val.hu_ones);
   assign ld[1] = load_val.hu_tens;
   assign ld[2] = load_val.hr_ones;
   assign ld[3] = load_val.hr_tens;

   assign hr_wrap = (dig[3] == HR_TOP_TENS) && (dig[2] == HR_TOP_ONES);

   always_comb begin
      inc[0] = step;
      inc[1] = carry[0];
      inc[2] = carry[1];
      inc[3] = carry[2] | (carry[1] & hr_wrap);
      clr    = {hr_wrap, hr_wrap, 2'b00};
   end

   for (genvar gi = 0; gi < TOD_DIGITS; gi++) begin : g_digit
      tod_digit #(
         .STEP (gi == 0 ? HU_STEP  : 1),
         .LAST (gi == 0 ? LOW_LAST : 9)
      ) i_digit (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load),
         .load_val (ld[gi]),
         .inc      (inc[gi]),
         .clr      (clr[gi]),
         .val_o    (dig[gi]),
         .carry_o  (carry[gi])
      );
   end

   assign time_o = '{hr_tens: dig[3], hr_ones: dig[2],
                     hu_tens: dig[1], hu_ones: dig[0]};

   // R3
   hu_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && dig[1] == 4'd9 && dig[0] == LOW_LAST_V)
      |=> (dig[1] == 4'd0 && dig[0] == 4'd0 && dig[2] != $past(dig[2])));

   // R4
   day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && hr_wrap && dig[1] == 4'd9 && dig[0] == LOW_LAST_V)
      |=> (time_o == '0));

   // R6
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (dig[3] == $past(ld[3]) && dig[2] == $past(ld[2]) &&
                dig[1] == $past(ld[1]) && dig[0] == $past(ld[0])));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(time_o));

   if (HU_STEP == 2) begin : g_even_chk
      // R5
      low_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !dig[0][0]);
   end

endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot
   import tod_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req,
   input  tod_time_t live,
   output tod_time_t data_o,
   output logic      valid_o
);

   tod_time_t data_q;
   logic      valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= req;
         if (req) begin
            data_q <= live;
         end
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;

   // R7
   snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (valid_o && data_o == $past(live)));

   // R7
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (!valid_o && $stable(data_o)));

endmodule

// File: rtl/tod_hundredths_clock.sv
module tod_hundredths_clock
   import tod_pkg::*;
#(
   parameter int unsigned PRESCALE      = 72_000_000,
   parameter int unsigned HOURS_PER_DAY = 24,
   parameter int unsigned HU_STEP       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [TOD_W-1:0]  load_time,
   input  logic              rd_req,
   output logic [TOD_W-1:0]  rd_time,
   output logic              rd_valid
);

   logic      step;
   tod_time_t live_time;
   tod_time_t snap_time;

   tod_prescaler #(
      .PRESCALE (PRESCALE)
   ) i_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load_en),
      .step_o  (step)
   );

   tod_digit_chain #(
      .HOURS_PER_DAY (HOURS_PER_DAY),
      .HU_STEP       (HU_STEP)
   ) i_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .load     (load_en),
      .load_val (tod_time_t'(load_time)),
      .time_o   (live_time)
   );

   tod_snapshot i_snapshot (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (rd_req),
      .live    (live_time),
      .data_o  (snap_time),
      .valid_o (rd_valid)
   );

   assign rd_time = snap_time;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (rd_valid == 1'b0 && live_time == '0));

endmodule

// File: tb/test_tod_hundredths_clock.sv
module test_tod_hundredths_clock;

   localparam int unsigned P = 4;

   typedef struct {
      logic [15:0] v;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_en = 1'b0;
   logic [15:0] load_time = '0;
   logic        rd_req = 1'b0;
   logic [15:0] rd_time;
   logic        rd_valid;

   int   n_tests = 0;
   int   n_fail  = 0;
   exp_t q[$];
   string cur_tag = "R1";

   int m_hr = 0, m_hu = 0, m_cnt = 0;

   always #5 clk = ~clk;

   tod_hundredths_clock #(.PRESCALE(P)) i_tod_hundredths_clock (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_time (load_time),
      .rd_req    (rd_req),
      .rd_time   (rd_time),
      .rd_valid  (rd_valid)
   );

   function automatic logic [15:0] to_bcd(input int hr, input int hu);
      return {4'(hr / 10), 4'(hr % 10), 4'(hu / 10), 4'(hu % 10)};
   endfunction

   // reference model: pushes expected snapshot on each request
   always @(posedge clk) begin
      if (!rst_n) begin
         m_hr = 0; m_hu = 0; m_cnt = 0;
      end else begin
         if (rd_req) begin
            exp_t e;
            e.v = to_bcd(m_hr, m_hu);
            e.tag = cur_tag;
            q.push_back(e);
         end
         if (load_en) begin
            m_hr  = 10 * int'(load_time[15:12]) + int'(load_time[11:8]);
            m_hu  = 10 * int'(load_time[7:4]) + int'(load_time[3:0] & 4'b1110);
            m_cnt = 0;
         end else if (m_cnt == P - 1) begin
            m_cnt = 0;
            m_hu  = m_hu + 2;
            if (m_hu >= 100) begin
               m_hu = 0;
               m_hr = (m_hr + 1) % 24;
            end
         end else begin
            m_cnt = m_cnt + 1;
         end
      end
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         n_tests++;
         if (q.size() == 0) begin
            n_fail++;
            $display("FAIL R7: unexpected rd_valid actual=%h expected=no response", rd_time);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (rd_time !== e.v) begin
               n_fail++;
               $display("FAIL %s: rd_time actual=%h expected=%h", e.tag, rd_time, e.v);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_load(input logic [15:0] v);
      load_en = 1'b1; load_time = v;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic do_reads(input string tag, input int n);
      cur_tag = tag;
      rd_req = 1'b1;
      repeat (n) @(negedge clk);
      rd_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R2: watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      n_tests++;
      if (rd_valid !== 1'b0 || rd_time !== 16'h0000) begin
         n_fail++;
         $display("FAIL R1: reset actual=%b/%h expected=0/0000", rd_valid, rd_time);
      end
      rst_n = 1'b1;
      do_reads("R1", 1);
      idle(2);
      // R2 stepping from reset, every cycle read
      do_reads("R2", 14);
      // R8 digit positions with distinct digits
      do_load(16'h1234);
      do_reads("R8", 2);
      // R5 odd low digit forced even
      do_load(16'h1235);
      do_reads("R5", 1);
      idle(3);
      // R3 hundredths rollover, snapshot across carry
      do_load(16'h0896);
      do_reads("R3", 12);
      // R3 hours units into tens
      do_load(16'h0998);
      do_reads("R3", 7);
      // R4 end of day
      do_load(16'h2396);
      do_reads("R4", 12);
      // R6 load on a due step: load at edge L+4 after previous load
      do_load(16'h0500);
      idle(3);
      do_load(16'h0700);
      do_reads("R6", 9);
      // R7 no request: no response, value held
      idle(6);
      n_tests++;
      if (rd_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R7: rd_valid actual=%b expected=0", rd_valid);
      end
      idle(2);
      n_tests++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R7: pending reads actual=%0d expected=0", q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule